// File: doc/BRIEF.md
# Acquisition Command and Event Status Registers

This block holds the host-visible control of a data-acquisition engine on an 8-bit register bus. A host write to the command address turns its upper five bits into one-cycle strobes for the sequencer and FIFO: arm, FIFO reset, queue reset, stop and latch. The lower command bits, scan rate and FIFO data mode, are kept as settings. A control register holds the pacer clock selection, the trigger settings, the continuous/one-shot choice and two interrupt enables. The block also tracks whether an acquisition is running.

The status register merges live FIFO levels and the run state with three sticky event flags: data lost, end of scan and FIFO threshold. Each flag is set by a one-cycle pulse from the sequencer or the FIFO. It stays set until the host reads the status register. A single interrupt line is raised while an enabled flag is pending. A typical host arms the engine, waits for the interrupt, reads the status to learn the cause and clear it, and drains the FIFO.

Top module: `acq_cmd_status`

## Requirements
- R1: After reset, the control register and the held command bits are 0, all strobes are low, running is 0, irq is 0, and a status read returns idle (bit 7) set with no event flag set.
- R2: A write to the command address (1) asserts, during the next cycle only, armPulse for data bit 7, fifoResetPulse for bit 6, queueResetPulse for bit 5, stopPulse for bit 4 and latchPulse for bit 3. A strobe may repeat only through another write.
- R3: Command data bits 2:1 (scanRate) and bit 0 (fifoDataMode) are held until the next command write. A read of address 1 returns them in bits 2:0, with bits 7:3 reading 0.
- R4: The control register at address 0 reads back as written. Its fields drive pacerSel (7:6), expansionEn (5), continuousMode (2), extTrigger (1) and fallingEdge (0). Bit 4 is the end-of-scan interrupt enable and bit 3 is the FIFO interrupt enable.
- R5: A read of the status address (2) returns idle in bit 7, running in bit 6, data lost in bit 5, end of scan in bit 4, threshold in bit 3, and the live fifoFull, fifoNearFull and fifoEmpty levels in bits 2, 1 and 0. Idle is always the inverse of running.
- R6: An event pulse sets its status flag from the next cycle. A status read returns the flags as they are and clears them at the end of that read cycle.
- R7: An event pulse that arrives in the same cycle as a status read leaves its flag set after the read.
- R8: irq is high exactly while the end-of-scan flag is set with control bit 4 set, or while the data-lost or threshold flag is set with control bit 3 set.
- R9: A command write with bit 7 set makes running 1 from the next cycle. A command write with bit 4 set makes running 0 from the next cycle. Stop wins when both bits are set.
- R10: A passDone pulse with continuousMode 0 returns running to 0 on the next cycle. With continuousMode 1 it has no effect. A command write in the same cycle takes priority.
- R11: When busRd is low, or the address is not 0, 1 or 2, busRdata is 0 and the event flags are not cleared. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Host write strobe, one cycle per write |
| busRd | input | 1 | Host read strobe, one cycle per read |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the read cycle |
| evDataLost | input | 1 | Data-lost event pulse |
| evEndOfScan | input | 1 | End-of-scan event pulse |
| evThreshold | input | 1 | FIFO threshold event pulse |
| passDone | input | 1 | Sequencer finished a pass |
| fifoFull | input | 1 | Live FIFO full level |
| fifoNearFull | input | 1 | Live FIFO near-full level |
| fifoEmpty | input | 1 | Live FIFO empty level |
| armPulse | output | 1 | Arm strobe |
| fifoResetPulse | output | 1 | FIFO reset strobe |
| queueResetPulse | output | 1 | Scan queue reset strobe |
| stopPulse | output | 1 | Stop strobe |
| latchPulse | output | 1 | Latch strobe |
| pacerSel | output | 2 | Pacer clock selection |
| expansionEn | output | 1 | Expansion mode enable |
| continuousMode | output | 1 | 1 continuous, 0 one-shot |
| extTrigger | output | 1 | External trigger source selected |
| fallingEdge | output | 1 | Trigger on falling edge |
| scanRate | output | 2 | Scan rate setting |
| fifoDataMode | output | 1 | FIFO data mode setting |
| running | output | 1 | Acquisition running |
| irq | output | 1 | Interrupt request |

## Verification
The flags are exercised with isolated event pulses, with an event placed in the same cycle as a status read, and with reads of unmapped addresses. Together these separate three behaviours: clear-on-read, keeping an event that coincides with a read, and the absence of side effects from other reads. The command writes cover a single arm, a stop, arm and stop together, and all strobe bits at once. They show which bit drives which strobe, that each strobe lasts one cycle, and that stop has priority. The passDone pulses are given in one-shot and in continuous mode, and the interrupt enables are toggled with flags pending, so that both mode and enable gating are seen.

// File: rtl/acq_reg_pkg.sv
package acq_reg_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_EVENTS = 3;
  localparam int NUM_PULSES = 5;
  localparam int PULSE_LSB  = BYTE_W - NUM_PULSES;

  // event flag indices (flag vector lands on status bits 5:3)
  localparam int EV_THRESH = 0;
  localparam int EV_EOS    = 1;
  localparam int EV_LOST   = 2;

  // strobe vector indices (command bits 7:3)
  localparam int P_LATCH = 0;
  localparam int P_STOP  = 1;
  localparam int P_QRST  = 2;
  localparam int P_FRST  = 3;
  localparam int P_ARM   = 4;

  // control register bit positions
  localparam int C_FIFO_IE = 3;
  localparam int C_EOS_IE  = 4;
  localparam int C_CONT    = 2;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrCmd;
    logic              rdStatus;
    logic              rdCtrl;
    logic              rdCmd;
    logic [BYTE_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/acq_reg_ctrl.sv
module acq_reg_ctrl
  import acq_reg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int ADDR_CTRL = 0,
  parameter int ADDR_CMD  = 1,
  parameter int ADDR_STAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BYTE_W-1:0]     busWdata,
  input  logic                  continuous,
  input  logic                  passDone,
  output regStrobe_t            strobe,
  output logic [NUM_PULSES-1:0] cmdPulse,
  output logic                  runQ
);
  logic selCtrl, selCmd, selStat;
  logic armReq, stopReq;

  always_comb begin
    selCtrl = (busAddr == ADDR_W'(ADDR_CTRL));
    selCmd  = (busAddr == ADDR_W'(ADDR_CMD));
    selStat = (busAddr == ADDR_W'(ADDR_STAT));
    strobe.wrCtrl   = busWr & selCtrl;
    strobe.wrCmd    = busWr & selCmd;
    strobe.rdStatus = busRd & selStat;
    strobe.rdCtrl   = busRd & selCtrl;
    strobe.rdCmd    = busRd & selCmd;
    strobe.wrData   = busWdata;
  end

  assign armReq  = strobe.wrCmd & busWdata[PULSE_LSB + P_ARM];
  assign stopReq = strobe.wrCmd & busWdata[PULSE_LSB + P_STOP];

  // self-clearing command strobes, one cycle after the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdPulse <= '0;
    else if (strobe.wrCmd) cmdPulse <= busWdata[BYTE_W-1:PULSE_LSB];
    else cmdPulse <= '0;
  end

  // run state: stop over arm over pass completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runQ <= 1'b0;
    else if (stopReq) runQ <= 1'b0;
    else if (armReq) runQ <= 1'b1;
    else if (passDone && !continuous) runQ <= 1'b0;
  end
endmodule

// File: rtl/acq_reg_datapath.sv
module acq_reg_datapath
  import acq_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              runQ,
  input  logic [NUM_EVENTS-1:0] evIn,
  input  logic [2:0]        levels,
  output logic [BYTE_W-1:0] ctrlQ,
  output logic [PULSE_LSB-1:0] cmdHeldQ,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq
);
  logic [NUM_EVENTS-1:0] flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      cmdHeldQ <= '0;
    end else begin
      if (strobe.wrCtrl) ctrlQ <= strobe.wrData;
      if (strobe.wrCmd)  cmdHeldQ <= strobe.wrData[PULSE_LSB-1:0];
    end
  end

  for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_flag
    logic flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ <= 1'b0;
      else flagQ <= (flagQ & ~strobe.rdStatus) | evIn[e];
    end
    assign flags[e] = flagQ;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdCtrl)   rdData = ctrlQ;
    if (strobe.rdCmd)    rdData = {{(BYTE_W-PULSE_LSB){1'b0}}, cmdHeldQ};
    if (strobe.rdStatus) rdData = {~runQ, runQ, flags, levels};
  end

  assign irq = (flags[EV_EOS] & ctrlQ[C_EOS_IE]) |
               ((flags[EV_LOST] | flags[EV_THRESH]) & ctrlQ[C_FIFO_IE]);
endmodule

// File: rtl/acq_cmd_status.sv
module acq_cmd_status
  import acq_reg_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int ADDR_CTRL = 0,
  parameter int ADDR_CMD  = 1,
  parameter int ADDR_STAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              evDataLost,
  input  logic              evEndOfScan,
  input  logic              evThreshold,
  input  logic              passDone,
  input  logic              fifoFull,
  input  logic              fifoNearFull,
  input  logic              fifoEmpty,
  output logic              armPulse,
  output logic              fifoResetPulse,
  output logic              queueResetPulse,
  output logic              stopPulse,
  output logic              latchPulse,
  output logic [1:0]        pacerSel,
  output logic              expansionEn,
  output logic              continuousMode,
  output logic              extTrigger,
  output logic              fallingEdge,
  output logic [1:0]        scanRate,
  output logic              fifoDataMode,
  output logic              running,
  output logic              irq
);
  regStrobe_t            strobe;
  logic [NUM_PULSES-1:0] cmdPulse;
  logic [BYTE_W-1:0]     ctrlQ;
  logic [PULSE_LSB-1:0]  cmdHeldQ;
  logic                  runQ;

  acq_reg_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_CMD(ADDR_CMD), .ADDR_STAT(ADDR_STAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .continuous(ctrlQ[C_CONT]), .passDone(passDone),
    .strobe(strobe), .cmdPulse(cmdPulse), .runQ(runQ)
  );

  acq_reg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .runQ(runQ),
    .evIn({evDataLost, evEndOfScan, evThreshold}),
    .levels({fifoFull, fifoNearFull, fifoEmpty}),
    .ctrlQ(ctrlQ), .cmdHeldQ(cmdHeldQ), .rdData(busRdata), .irq(irq)
  );

  assign armPulse        = cmdPulse[P_ARM];
  assign fifoResetPulse  = cmdPulse[P_FRST];
  assign queueResetPulse = cmdPulse[P_QRST];
  assign stopPulse       = cmdPulse[P_STOP];
  assign latchPulse      = cmdPulse[P_LATCH];
  assign pacerSel        = ctrlQ[7:6];
  assign expansionEn     = ctrlQ[5];
  assign continuousMode  = ctrlQ[C_CONT];
  assign extTrigger      = ctrlQ[1];
  assign fallingEdge     = ctrlQ[0];
  assign scanRate        = cmdHeldQ[2:1];
  assign fifoDataMode    = cmdHeldQ[0];
  assign running         = runQ;
endmodule

// File: rtl/acq_cmd_status_chk.sv
module acq_cmd_status_chk #(
  parameter int ADDR_W    = 3,
  parameter int ADDR_CMD  = 1,
  parameter int ADDR_STAT = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic              evDataLost,
  input logic              evEndOfScan,
  input logic              evThreshold,
  input logic              armPulse,
  input logic              stopPulse,
  input logic              running,
  input logic              irq
);
  logic statRd, cmdWr;
  assign statRd = busRd && (busAddr == ADDR_W'(ADDR_STAT));
  assign cmdWr  = busWr && (busAddr == ADDR_W'(ADDR_CMD));

  AST_ARM_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    armPulse |-> $past(cmdWr && busWdata[7])); // R2
  AST_STOP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> $past(cmdWr && busWdata[4])); // R2
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> !running); // R9
  AST_ARM_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (armPulse && !stopPulse) |-> running); // R9
  AST_IDLE_RUN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    statRd |-> (busRdata[7] != busRdata[6])); // R5
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && evEndOfScan) ##1 statRd |-> busRdata[4]); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(evDataLost || evEndOfScan || evThreshold || busWr)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr > ADDR_W'(ADDR_STAT)) |-> (busRdata == 8'h00)); // R11
endmodule

bind acq_cmd_status acq_cmd_status_chk #(
  .ADDR_W(ADDR_W), .ADDR_CMD(ADDR_CMD), .ADDR_STAT(ADDR_STAT)
) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .evDataLost(evDataLost),
  .evEndOfScan(evEndOfScan), .evThreshold(evThreshold), .armPulse(armPulse),
  .stopPulse(stopPulse), .running(running), .irq(irq)
);

// File: tb/test_acq_cmd_status.sv
`timescale 1ns/100ps
module test_acq_cmd_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 0, busRd = 0;
  logic [2:0] busAddr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic evDataLost = 0, evEndOfScan = 0, evThreshold = 0, passDone = 0;
  logic fifoFull = 0, fifoNearFull = 0, fifoEmpty = 0;
  logic armPulse, fifoResetPulse, queueResetPulse, stopPulse, latchPulse;
  logic [1:0] pacerSel, scanRate;
  logic expansionEn, continuousMode, extTrigger, fallingEdge, fifoDataMode, running, irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  acq_cmd_status i_acq_cmd_status (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evDataLost(evDataLost),
    .evEndOfScan(evEndOfScan), .evThreshold(evThreshold), .passDone(passDone),
    .fifoFull(fifoFull), .fifoNearFull(fifoNearFull), .fifoEmpty(fifoEmpty),
    .armPulse(armPulse), .fifoResetPulse(fifoResetPulse),
    .queueResetPulse(queueResetPulse), .stopPulse(stopPulse), .latchPulse(latchPulse),
    .pacerSel(pacerSel), .expansionEn(expansionEn), .continuousMode(continuousMode),
    .extTrigger(extTrigger), .fallingEdge(fallingEdge), .scanRate(scanRate),
    .fifoDataMode(fifoDataMode), .running(running), .irq(irq)
  );

  // behavioural reference model
  int mCtrl, mCmd, mFlags, mRun, mPulse;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtrl = 0; mCmd = 0; mFlags = 0; mRun = 0; mPulse = 0;
    end else begin
      if (busWr && busAddr == 1) begin
        mPulse = busWdata >> 3;
        if (busWdata[4]) mRun = 0;
        else if (busWdata[7]) mRun = 1;
      end else begin
        mPulse = 0;
        if (passDone && ((mCtrl & 4) == 0)) mRun = 0;
      end
      if (busRd && busAddr == 2) mFlags = 0;
      mFlags = mFlags | (evDataLost ? 4 : 0) | (evEndOfScan ? 2 : 0) | (evThreshold ? 1 : 0);
      if (busWr && busAddr == 1) mCmd = busWdata & 7;
      if (busWr && busAddr == 0) mCtrl = busWdata;
    end
  end

  function automatic int expRead();
    if (!busRd) return 0;
    case (busAddr)
      3'd0: return mCtrl;
      3'd1: return mCmd;
      3'd2: return ((mRun != 0) ? 8'h40 : 8'h80) | (mFlags << 3) |
                   (fifoFull ? 4 : 0) | (fifoNearFull ? 2 : 0) | (fifoEmpty ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic int expIrq();
    return ((((mFlags & 2) != 0) && ((mCtrl & 8'h10) != 0)) ||
            (((mFlags & 5) != 0) && ((mCtrl & 8'h08) != 0))) ? 1 : 0;
  endfunction

  task automatic chk(input int act, input int exp, input string req, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    string rq;
    case (busAddr)
      3'd0: rq = "R4";
      3'd1: rq = "R3";
      3'd2: rq = "R5";
      default: rq = "R11";
    endcase
    chk(busRdata, expRead(), rq, "read data");
    chk(irq, expIrq(), "R8", "irq");
    chk(running, mRun, "R9", "running");
    chk({armPulse, fifoResetPulse, queueResetPulse, stopPulse, latchPulse}, mPulse, "R2", "strobes");
    chk({pacerSel, expansionEn, 2'b00, continuousMode, extTrigger, fallingEdge},
        mCtrl & 8'hE7, "R4", "control outputs");
    chk({scanRate, fifoDataMode}, mCmd, "R3", "command outputs");
  endtask

  // one cycle: drive at negedge, compare 1 ns later
  task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                     input logic [7:0] d, input logic [2:0] ev, input logic pd);
    @(negedge clk);
    busWr = wr; busRd = rd; busAddr = a; busWdata = d;
    {evDataLost, evEndOfScan, evThreshold} = ev;
    passDone = pd;
    #1 compareAll();
  endtask

  task automatic idle();       cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); cyc(1, 0, a, d, 0, 0); endtask
  task automatic rd(input logic [2:0] a); cyc(0, 1, a, 0, 0, 0); endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    fifoEmpty = 1;
    repeat (3) @(negedge clk);
    #1 compareAll();
    rstN = 1'b1;
    rd(2); chk(busRdata, 8'h81, "R1", "status after reset");
    chk(irq, 0, "R1", "irq after reset");

    wr(0, 8'h18);
    rd(0); chk(busRdata, 8'h18, "R4", "control readback");
    wr(1, 8'h85);
    rd(1); chk(armPulse, 1, "R2", "arm strobe");
    chk(running, 1, "R9", "arm runs");
    chk(busRdata, 8'h05, "R3", "held command bits");
    idle(); chk(armPulse, 0, "R2", "arm strobe one cycle");

    fifoEmpty = 0; fifoNearFull = 1;
    cyc(0, 0, 0, 0, 3'b001, 0);
    rd(2); chk(irq, 1, "R8", "threshold irq");
    chk(busRdata, 8'h4A, "R6", "threshold flag");
    rd(2); chk(busRdata, 8'h42, "R6", "flag cleared by read");
    chk(irq, 0, "R8", "irq released");

    cyc(0, 1, 2, 0, 3'b010, 0); chk(busRdata, 8'h42, "R7", "read before event");
    rd(2); chk(busRdata, 8'h52, "R7", "coincident event kept");
    rd(2); chk(busRdata, 8'h42, "R6", "cleared after");

    cyc(0, 0, 0, 0, 3'b100, 0);
    rd(5); chk(busRdata, 0, "R11", "unmapped read");
    wr(6, 8'hFF);
    cyc(0, 0, 2, 0, 0, 0); chk(busRdata, 0, "R11", "no read strobe");
    rd(0); chk(busRdata, 8'h18, "R11", "unmapped write ignored");
    chk(irq, 1, "R11", "flag kept after other reads");
    rd(2); chk(busRdata, 8'h62, "R6", "data lost flag");

    wr(0, 8'h00);
    cyc(0, 0, 0, 0, 0, 1);
    idle(); chk(running, 0, "R10", "one-shot pass ends run");
    wr(1, 8'h80);
    wr(0, 8'h04);
    cyc(0, 0, 0, 0, 0, 1);
    idle(); chk(running, 1, "R10", "continuous ignores pass");
    wr(1, 8'h10);
    idle(); chk(running, 0, "R9", "stop idles");
    chk(stopPulse, 1, "R2", "stop strobe");

    wr(1, 8'h80);
    wr(1, 8'h90);
    idle(); chk(running, 0, "R9", "stop wins over arm");
    chk({armPulse, stopPulse}, 2'b11, "R2", "both strobes");

    wr(1, 8'hF8);
    rd(1); chk({armPulse, fifoResetPulse, queueResetPulse, stopPulse, latchPulse},
               5'h1F, "R2", "all strobes");
    chk(busRdata, 0, "R3", "held bits rewritten");

    wr(0, 8'hC3);
    cyc(0, 0, 0, 0, 3'b010, 0);
    idle(); chk(irq, 0, "R8", "eos gated off");
    wr(0, 8'h10);
    idle(); chk(irq, 1, "R8", "eos enabled");
    wr(0, 8'h08);
    idle(); chk(irq, 0, "R8", "eos not under fifo enable");
    rd(2);
    idle(); idle();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule